// File: doc/BRIEF.md
# SPI NOR flash command sequencer

This block is the byte-level command engine of a serial NOR flash slave. A bit shifter in front of it supplies one received byte per transfer on `rx_valid`/`rx_byte` and a one-cycle `cs_start` pulse each time chip select goes active. For every accepted byte the sequencer produces one response byte. The first byte after select is an opcode. Depending on the opcode, the block then gathers address, dummy or parameter bytes, streams array data, passes bytes on for programming, or returns a short register readout.

The array itself sits in a separate storage engine. The sequencer gives it a read address and takes the read byte back combinationally. It also sends one-cycle program and erase requests. Inside the block it keeps a write-enable latch, a 4-byte addressing flag, an extended segment register and a volatile configuration byte. The upper nibble of that configuration byte sets how many dummy bytes the fast-read opcodes expect. Device size, identification code and the configuration reset value are parameters. Dummy clocks count as whole bytes.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: A byte accepted with `rx_valid` high and `cs_start` low raises `tx_valid` for exactly one cycle, in the cycle after it. `tx_byte` then carries the response, which is 0x00 for opcodes, for collected bytes and for program data. `tx_valid` is low in every other cycle.
- R2: `cs_start` returns the block to the idle phase and aborts any collection, readout, read stream or program stream, so the next byte is decoded as an opcode. A byte presented in the same cycle as `cs_start` is dropped.
- R3: Write enable is clear after reset. Opcode 0x06 sets it and 0x04 clears it. Opcode 0x05 returns one byte with write enable in bit 1 and all other bits zero.
- R4: Opcode 0xB7 sets 4-byte addressing and 0xE9 clears it. Opcode 0x70 returns one byte equal to 0x80, with bit 0 set while 4-byte addressing is on.
- R5: Opcode 0x9F returns the three bytes of `ID_CODE`, most significant first. If `ID_EXT` is nonzero, its two bytes follow, most significant first. After the last byte, the next byte is decoded as an opcode.
- R6: The address is 4 bytes for opcodes 0x13, 0x12, 0x21, 0xDC, 0x0C, 0x3C, 0x6C, 0xBC and 0xEC. For the other address-taking opcodes it is 4 bytes while 4-byte addressing is on and 3 bytes otherwise. Address bytes arrive most significant first.
- R7: With a 3-byte address, bits 1:0 of the extended segment register become address bits 25:24. Opcode 0xC8 returns that register. Opcode 0xC5 with write enable takes one byte into it.
- R8: The fast-read opcodes 0x0B, 0x0C, 0x3B, 0x3C, 0x6B, 0x6C, 0xBB, 0xBC, 0xEB and 0xEC expect, after the address, as many dummy bytes as bits 7:4 of the configuration byte. Opcode 0x85 returns the configuration byte. Opcode 0x81 with write enable writes it.
- R9: After a read opcode (0x03, 0x13 or fast read) and its address, each byte returns `rd_data` for the current address. The address then advances modulo 2^`SIZE_LOG2`, and `rd_addr` shows it.
- R10: After 0x02 or 0x12 and the address, each byte causes a `prog_req` pulse one cycle later. The pulse carries `prog_addr` equal to the current address and `prog_data` equal to the byte. The address then advances by one.
- R11: An erase is requested only while write enable is set. Opcodes 0x20 and 0x21 give kind 0, 0x52 gives kind 1, and 0xD8 and 0xDC give kind 2. Each pulses `erase_req` one cycle after the last address byte, with the assembled `erase_addr`. Opcode 0xC7 gives kind 3 with address 0, one cycle after the opcode. Without write enable, neither produces a request.
- R12: Opcodes 0x01, 0xC5 and 0x81 take one parameter byte only while write enable is set. Otherwise they are single-byte no-ops, and the following byte is decoded as an opcode. A completed 0x01 clears write enable.
- R13: Any other opcode has no effect: it gives a 0x00 response, issues no request and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_start | input | 1 | One-cycle pulse when chip select becomes active |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte valid |
| tx_byte | output | 8 | Response byte |
| rd_addr | output | SIZE_LOG2 | Array read address |
| rd_data | input | 8 | Array byte at `rd_addr` |
| prog_req | output | 1 | Program one byte |
| prog_addr | output | 32 | Program address |
| prog_data | output | 8 | Program data |
| erase_req | output | 1 | Erase request |
| erase_kind | output | 2 | 0: 4 KiB, 1: 32 KiB, 2: sector, 3: whole device |
| erase_addr | output | 32 | Erase address |

## Verification
Every result is registered once. The response byte and any program or erase pulse for a byte taken at one rising edge are visible in the cycle that follows. A `cs_start` takes effect at its own edge. Array data for a read byte comes from `rd_addr`, which is stable during the byte's cycle. The bench keeps a behavioural model of the command set. That model updates its expectations in the same step that drives each byte. The bench compares all outputs at the next falling edge, and also compares them in idle cycles, where no output may pulse.

// File: rtl/spi_nor_cmd_seq.sv
module spi_nor_cmd_seq #(
  parameter int          SIZE_LOG2 = 24,
  parameter logic [23:0] ID_CODE   = 24'h20BA18,
  parameter logic [15:0] ID_EXT    = 16'h0000,
  parameter logic [7:0]  VCFG_RST  = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_start,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  output logic                 tx_valid,
  output logic [7:0]           tx_byte,
  output logic [SIZE_LOG2-1:0] rd_addr,
  input  logic [7:0]           rd_data,
  output logic                 prog_req,
  output logic [31:0]          prog_addr,
  output logic [7:0]           prog_data,
  output logic                 erase_req,
  output logic [1:0]           erase_kind,
  output logic [31:0]          erase_addr
);
  localparam logic [31:0] SIZE_MASK = 32'((64'd1 << SIZE_LOG2) - 64'd1);
  localparam logic [2:0]  ID_LEN    = (ID_EXT != 16'h0) ? 3'd5 : 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_COLLECT, S_REPLY, S_READ, S_PROG} st_t;

  st_t         state;
  logic [7:0]  op, ear, vcfg;
  logic        wel, four_b;
  logic [2:0]  addr_len, rleft;
  logic [4:0]  need, cnt;
  logic [31:0] addr_sh, cur_addr;
  logic [39:0] rsh;

  function automatic logic op_a4(input logic [7:0] o);
    case (o)
      8'h13, 8'h12, 8'h21, 8'hDC, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_fast(input logic [7:0] o);
    case (o)
      8'h0B, 8'h0C, 8'h3B, 8'h3C, 8'h6B, 8'h6C, 8'hBB, 8'hBC, 8'hEB, 8'hEC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_erase(input logic [7:0] o);
    case (o)
      8'h20, 8'h21, 8'h52, 8'hD8, 8'hDC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] erase_code(input logic [7:0] o);
    case (o)
      8'h20, 8'h21: return 2'd0;
      8'h52:        return 2'd1;
      default:      return 2'd2;
    endcase
  endfunction

  wire         is_pp    = (rx_byte == 8'h02) || (rx_byte == 8'h12);
  wire         is_rd    = (rx_byte == 8'h03) || (rx_byte == 8'h13);
  wire         op_is_pp = (op == 8'h02) || (op == 8'h12);
  wire         op_is_rd = (op == 8'h03) || (op == 8'h13) || op_fast(op);
  wire [2:0]   dec_alen = (op_a4(rx_byte) || four_b) ? 3'd4 : 3'd3;
  wire [31:0]  sh_nx    = (cnt < {2'b00, addr_len}) ? {addr_sh[23:0], rx_byte} : addr_sh;
  wire [31:0]  asm_addr = (addr_len == 3'd4) ? sh_nx : {6'b0, ear[1:0], sh_nx[23:0]};
  wire         last     = (cnt + 5'd1) == need;

  assign rd_addr = cur_addr[SIZE_LOG2-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  op <= 8'h00;  ear <= 8'h00;  vcfg <= VCFG_RST;
      wel <= 1'b0;  four_b <= 1'b0;  addr_len <= 3'd3;  rleft <= 3'd0;
      need <= 5'd0;  cnt <= 5'd0;  addr_sh <= 32'h0;  cur_addr <= 32'h0;
      rsh <= 40'h0;  tx_valid <= 1'b0;  tx_byte <= 8'h00;
      prog_req <= 1'b0;  prog_addr <= 32'h0;  prog_data <= 8'h00;
      erase_req <= 1'b0;  erase_kind <= 2'd0;  erase_addr <= 32'h0;
    end else begin
      tx_valid  <= 1'b0;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      if (cs_start) begin
        state <= S_IDLE;
        cnt   <= 5'd0;
        rleft <= 3'd0;
      end else if (rx_valid) begin
        tx_valid <= 1'b1;
        tx_byte  <= 8'h00;
        case (state)
          S_IDLE: begin
            op       <= rx_byte;
            cnt      <= 5'd0;
            addr_sh  <= 32'h0;
            addr_len <= dec_alen;
            if (is_pp || is_rd || op_erase(rx_byte)) begin
              need  <= {2'b00, dec_alen};
              state <= S_COLLECT;
            end else if (op_fast(rx_byte)) begin
              need  <= {2'b00, dec_alen} + {1'b0, vcfg[7:4]};
              state <= S_COLLECT;
            end else begin
              case (rx_byte)
                8'h01, 8'hC5, 8'h81: if (wel) begin need <= 5'd1; state <= S_COLLECT; end
                8'h04: wel <= 1'b0;
                8'h06: wel <= 1'b1;
                8'h05: begin rsh <= {6'b0, wel, 1'b0, 32'h0}; rleft <= 3'd1; state <= S_REPLY; end
                8'h70: begin rsh <= {1'b1, 6'b0, four_b, 32'h0}; rleft <= 3'd1; state <= S_REPLY; end
                8'h9F: begin rsh <= {ID_CODE, ID_EXT}; rleft <= ID_LEN; state <= S_REPLY; end
                8'hC8: begin rsh <= {ear, 32'h0}; rleft <= 3'd1; state <= S_REPLY; end
                8'h85: begin rsh <= {vcfg, 32'h0}; rleft <= 3'd1; state <= S_REPLY; end
                8'hB7: four_b <= 1'b1;
                8'hE9: four_b <= 1'b0;
                8'hC7: if (wel) begin
                  erase_req  <= 1'b1;
                  erase_kind <= 2'd3;
                  erase_addr <= 32'h0;
                end
                default: ;
              endcase
            end
          end
          S_COLLECT: begin
            cnt     <= cnt + 5'd1;
            addr_sh <= sh_nx;
            if (last) begin
              state <= S_IDLE;
              if (op_is_rd) begin
                state    <= S_READ;
                cur_addr <= asm_addr;
              end else if (op_is_pp) begin
                state    <= S_PROG;
                cur_addr <= asm_addr;
              end else if (op_erase(op)) begin
                if (wel) begin
                  erase_req  <= 1'b1;
                  erase_kind <= erase_code(op);
                  erase_addr <= asm_addr;
                end
              end else begin
                case (op)
                  8'h01:   wel  <= 1'b0;
                  8'hC5:   ear  <= rx_byte;
                  8'h81:   vcfg <= rx_byte;
                  default: ;
                endcase
              end
            end
          end
          S_REPLY: begin
            tx_byte <= rsh[39:32];
            rsh     <= {rsh[31:0], 8'h00};
            rleft   <= rleft - 3'd1;
            if (rleft == 3'd1) state <= S_IDLE;
          end
          S_READ: begin
            tx_byte  <= rd_data;
            cur_addr <= (cur_addr + 32'd1) & SIZE_MASK;
          end
          S_PROG: begin
            prog_req  <= 1'b1;
            prog_addr <= cur_addr;
            prog_data <= rx_byte;
            cur_addr  <= cur_addr + 32'd1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_nor_cmd_seq_sva.sv
module spi_nor_cmd_seq_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_start,
  input logic        rx_valid,
  input logic [7:0]  rx_byte,
  input logic        tx_valid,
  input logic [7:0]  tx_byte,
  input logic        prog_req,
  input logic [7:0]  prog_data,
  input logic        erase_req,
  input logic [1:0]  erase_kind,
  input logic [31:0] erase_addr
);
  p_tx_after_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cs_start) |=> tx_valid);

  p_tx_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && !cs_start) |=> !tx_valid);

  p_cs_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (!prog_req && !erase_req));

  p_prog_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (tx_valid && tx_byte == 8'h00));

  p_prog_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cs_start) |=> (!prog_req || prog_data == $past(rx_byte)));

  p_erase_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !prog_req);

  p_chip_erase_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_kind == 2'd3) |-> erase_addr == 32'h0);
endmodule

bind spi_nor_cmd_seq spi_nor_cmd_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rx_valid(rx_valid),
  .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .prog_req(prog_req), .prog_data(prog_data), .erase_req(erase_req),
  .erase_kind(erase_kind), .erase_addr(erase_addr)
);

// File: tb/test_spi_nor_cmd_seq.sv
module test_spi_nor_cmd_seq;
  localparam int          SZ   = 24;
  localparam logic [23:0] IDC  = 24'hC84017;
  localparam logic [15:0] IDX  = 16'h4D01;
  localparam longint      SIZE = 64'd1 << SZ;

  logic clk = 1'b0, rst_n = 1'b0, cs_start = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_valid, prog_req, erase_req;
  logic [7:0] tx_byte, prog_data, rd_data;
  logic [SZ-1:0] rd_addr;
  logic [31:0] prog_addr, erase_addr;
  logic [1:0] erase_kind;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input longint a);
    logic [23:0] x;
    x = 24'(a % SIZE);
    return x[7:0] ^ x[15:8] ^ x[23:16] ^ 8'h5A;
  endfunction

  assign rd_data = memf(longint'(rd_addr));

  spi_nor_cmd_seq #(.SIZE_LOG2(SZ), .ID_CODE(IDC), .ID_EXT(IDX), .VCFG_RST(8'h00)) i_spi_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_kind(erase_kind), .erase_addr(erase_addr));

  int tests = 0, fails = 0;
  string tag = "R1", etag = "R1";

  // expectations for the next cycle
  logic e_tv = 0, e_pr = 0, e_er = 0;
  logic [7:0] e_tx = 0, e_pd = 0;
  logic [31:0] e_pa = 0, e_ea = 0;
  logic [1:0] e_ek = 0;

  // behavioural model state
  int m_state = 0;                    // 0 idle, 1 collect, 2 reply, 3 read, 4 program
  logic [7:0] m_op = 0, m_ear = 0, m_vcfg = 0;
  logic m_wel = 0, m_4b = 0;
  int m_alen = 3, m_need = 0;
  longint m_addr = 0;
  logic [7:0] coll[$];
  logic [7:0] rq[$];

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic check_out();
    logic bad;
    tests++;
    bad = (tx_valid !== e_tv) || (e_tv && tx_byte !== e_tx) ||
          (prog_req !== e_pr) || (e_pr && (prog_addr !== e_pa || prog_data !== e_pd)) ||
          (erase_req !== e_er) || (e_er && (erase_kind !== e_ek || erase_addr !== e_ea));
    if (bad) begin
      fails++;
      $display("FAIL %s: actual tv=%0b tx=%02h pr=%0b pa=%08h pd=%02h er=%0b ek=%0d ea=%08h expected tv=%0b tx=%02h pr=%0b pa=%08h pd=%02h er=%0b ek=%0d ea=%08h",
               etag, tx_valid, tx_byte, prog_req, prog_addr, prog_data, erase_req, erase_kind, erase_addr,
               e_tv, e_tx, e_pr, e_pa, e_pd, e_er, e_ek, e_ea);
    end
  endtask

  task automatic model(input logic cs, input logic v, input logic [7:0] b);
    longint a;
    e_tv = 0; e_tx = 0; e_pr = 0; e_er = 0;
    etag = tag;
    if (cs) begin
      m_state = 0; coll.delete(); rq.delete();
      return;
    end
    if (!v) begin etag = "R1"; return; end
    e_tv = 1;
    case (m_state)
      0: begin
        m_op = b; coll.delete();
        m_alen = ((b inside {8'h13,8'h12,8'h21,8'hDC,8'h0C,8'h3C,8'h6C,8'hBC,8'hEC}) || m_4b) ? 4 : 3;
        if (b inside {8'h03,8'h13,8'h02,8'h12,8'h20,8'h21,8'h52,8'hD8,8'hDC}) begin
          m_need = m_alen; m_state = 1;
        end else if (b inside {8'h0B,8'h0C,8'h3B,8'h3C,8'h6B,8'h6C,8'hBB,8'hBC,8'hEB,8'hEC}) begin
          m_need = m_alen + int'(m_vcfg[7:4]); m_state = 1;
        end else begin
          case (b)
            8'h01, 8'hC5, 8'h81: if (m_wel) begin m_need = 1; m_state = 1; end
            8'h04: m_wel = 0;
            8'h06: m_wel = 1;
            8'h05: begin rq.push_back(m_wel ? 8'h02 : 8'h00); m_state = 2; end
            8'h70: begin rq.push_back(m_4b ? 8'h81 : 8'h80); m_state = 2; end
            8'h9F: begin
              rq.push_back(IDC[23:16]); rq.push_back(IDC[15:8]); rq.push_back(IDC[7:0]);
              if (IDX != 0) begin rq.push_back(IDX[15:8]); rq.push_back(IDX[7:0]); end
              m_state = 2;
            end
            8'hC8: begin rq.push_back(m_ear); m_state = 2; end
            8'h85: begin rq.push_back(m_vcfg); m_state = 2; end
            8'hB7: m_4b = 1;
            8'hE9: m_4b = 0;
            8'hC7: if (m_wel) begin e_er = 1; e_ek = 3; e_ea = 0; end
            default: ;
          endcase
        end
      end
      1: begin
        coll.push_back(b);
        if (coll.size() == m_need) begin
          a = 0;
          if (m_need >= m_alen)
            for (int i = 0; i < m_alen; i++) a = a * 256 + longint'(coll[i]);
          if (m_alen == 3) a = a + longint'(m_ear[1:0]) * 64'h1000000;
          m_state = 0;
          if (m_op inside {8'h03,8'h13,8'h0B,8'h0C,8'h3B,8'h3C,8'h6B,8'h6C,8'hBB,8'hBC,8'hEB,8'hEC}) begin
            m_state = 3; m_addr = a;
          end else if (m_op inside {8'h02,8'h12}) begin
            m_state = 4; m_addr = a;
          end else if (m_op inside {8'h20,8'h21,8'h52,8'hD8,8'hDC}) begin
            if (m_wel) begin
              e_er = 1; e_ea = 32'(a);
              e_ek = (m_op inside {8'h20,8'h21}) ? 2'd0 : (m_op == 8'h52) ? 2'd1 : 2'd2;
            end
          end else if (m_op == 8'h01) m_wel = 0;
          else if (m_op == 8'hC5) m_ear = coll[0];
          else if (m_op == 8'h81) m_vcfg = coll[0];
        end
      end
      2: begin
        e_tx = rq.pop_front();
        if (rq.size() == 0) m_state = 0;
      end
      3: begin
        e_tx = memf(m_addr);
        m_addr = (m_addr % SIZE + 1) % SIZE;
      end
      default: begin
        e_pr = 1; e_pa = 32'(m_addr); e_pd = b;
        m_addr = m_addr + 1;
      end
    endcase
  endtask

  task automatic cyc(input logic cs, input logic v, input logic [7:0] b);
    @(negedge clk);
    check_out();
    cs_start = cs; rx_valid = v; rx_byte = b;
    model(cs, v, b);
  endtask

  task automatic sb(input logic [7:0] b); cyc(0, 1, b); endtask
  task automatic sel(); cyc(1, 0, 8'h00); endtask
  task automatic gap(); cyc(0, 0, 8'h00); endtask

  initial begin
    #10000000;
    fails++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; gap(); gap();                                  // reset state: outputs quiet

    tag = "R3"; sel(); sb(8'h05); sb(8'hFF);                   // wel clear after reset
    sel(); sb(8'h06); sb(8'h05); sb(8'h00); sb(8'h04); sb(8'h05); sb(8'h00); gap();

    tag = "R4"; sel(); sb(8'h70); sb(8'h00); sb(8'hB7); sb(8'h70); sb(8'h00);
    sb(8'hE9); sb(8'h70); sb(8'h00);

    tag = "R5"; sel(); sb(8'h9F); for (int i = 0; i < 5; i++) sb(8'h00);
    sb(8'h06); sb(8'h05); sb(8'h00); sb(8'h04);

    tag = "R10"; sel(); sb(8'h06); sb(8'h02); sb(8'h01); sb(8'h02); sb(8'h03);
    sb(8'hA5); gap(); sb(8'h3C); sb(8'h00);
    tag = "R6"; sel(); sb(8'h12); sb(8'h11); sb(8'h22); sb(8'h33); sb(8'h44); sb(8'h77);
    sel(); sb(8'hB7); sb(8'h02); sb(8'h0A); sb(8'h0B); sb(8'h0C); sb(8'h0D); sb(8'h99); sb(8'h98);
    sel(); sb(8'hE9);

    tag = "R7"; sel(); sb(8'hC5); sb(8'h02); sb(8'hC8); sb(8'h00);
    sel(); sb(8'h20); sb(8'h12); sb(8'h34); sb(8'h56);
    sb(8'h21); sb(8'h01); sb(8'h02); sb(8'h03); sb(8'h04);
    sb(8'h03); sb(8'h00); sb(8'h10); sb(8'h00); sb(8'h00); sb(8'h00);
    sel(); sb(8'h06); sb(8'hC5); sb(8'h00);

    tag = "R8"; sel(); sb(8'h81); sb(8'h20); sb(8'h85); sb(8'h00);
    sel(); sb(8'h0B); sb(8'h00); sb(8'h01); sb(8'h00); sb(8'hEE); sb(8'hEE);
    sb(8'h00); sb(8'h00); sb(8'h00);
    sel(); sb(8'h6C); sb(8'h00); sb(8'h00); sb(8'h20); sb(8'h40); sb(8'h00); sb(8'h00); sb(8'h00); sb(8'h00);
    sel(); sb(8'h06); sb(8'h81); sb(8'h00);

    tag = "R9"; sel(); sb(8'h03); sb(8'hFF); sb(8'hFF); sb(8'hFE);
    for (int i = 0; i < 4; i++) sb(8'h00);
    gap(); sb(8'h00);

    tag = "R11"; sel(); sb(8'h06); sb(8'h52); sb(8'h00); sb(8'h80); sb(8'h00);
    sb(8'hD8); sb(8'h12); sb(8'h00); sb(8'h00);
    sb(8'hDC); sb(8'h01); sb(8'h00); sb(8'h00); sb(8'h00);
    sb(8'hC7); gap();
    sb(8'h04); sb(8'hC7); sb(8'h20); sb(8'h00); sb(8'h10); sb(8'h00); gap();

    tag = "R12"; sel(); sb(8'h81); sb(8'hB7); sb(8'h70); sb(8'h00); sb(8'hE9);
    sb(8'hC5); sb(8'h70); sb(8'h00);
    sb(8'h06); sb(8'h01); sb(8'h00); sb(8'h05); sb(8'h00);

    tag = "R2"; sel(); sb(8'h03); sb(8'h01); sb(8'h02); sel(); sb(8'h05); sb(8'h00);
    sel(); sb(8'h9F); sb(8'h00); sel(); sb(8'h70); sb(8'h00);
    sel(); sb(8'h06); sb(8'h02); sb(8'h00); sb(8'h00); sb(8'h00); sb(8'h55);
    sel(); sb(8'h55); sb(8'h05); sb(8'h00);
    cyc(1, 1, 8'h06); sb(8'h04); sb(8'h05); sb(8'h00);

    tag = "R13"; sel(); sb(8'hAA); sb(8'h00); sb(8'h05); sb(8'h00);
    gap(); gap();

    summary();
    $finish;
  end
endmodule